// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is one stage of an up-counter whose width is a build parameter (four bits by default). On each rising clock edge the stage either clears to zero, takes a parallel data word, advances by one or keeps its value. Clear and load are active low. Counting needs two enables, P and T, to be high together. Every state bit is a flip-flop on the same clock, so all count bits change on the same edge.

A terminal-count carry goes high while T is high and the count is all ones. P has no effect on this carry. Wider synchronous counters are built by driving both enables of each stage from the carry of the stage below it, with no extra gating.

A build parameter chooses between two clear behaviours. In one, clear is asynchronous and zeroes the count as soon as it goes low. In the other, clear is sampled on the next rising edge like any other control input.

Top module: `casc_counter`

## Requirements
- R1: With clear and load inactive (high) and both P and T high, each rising edge adds one to the count, and the count wraps from all ones (15 at the default width) to 0.
- R2: With clear and load inactive and P or T low, the count keeps its value across the edge.
- R3: With clear high and load low, the next rising edge copies the data input to the count, whatever the levels of P and T.
- R4: Priority runs clear, then load, then counting, then hold. A low clear wins over a low load on the same edge.
- R5: With ASYNC_CLR = 0, a low clear has no effect until the next rising edge, and that edge sets the count to 0.
- R6: With ASYNC_CLR = 1, a low clear sets the count to 0 at once, without waiting for a clock edge, and holds it at 0 while clear stays low.
- R7: The carry output is high exactly when T is high and the count is all ones. P has no effect on it. It is combinational, so it falls in the same cycle that T falls.
- R8: Stages chained so that both enables of stage k+1 come from the carry of stage k count as one wide binary counter. The chain carries across stage boundaries, wraps from all ones to zero, and loads a full-width word into all stages on one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous according to ASYNC_CLR |
| ld_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| d | input | WIDTH | Parallel load word |
| q | output | WIDTH | Current count |
| rco | output | 1 | Terminal-count carry: high when en_t is high and q is all ones |

## Verification
Assertions run on every cycle and check the per-edge transitions: a load takes the sampled data, a count adds one, a disabled stage holds, and a clear gives zero on the edge (synchronous variant) or while clear is low (asynchronous variant). They also check that the carry is never high unless T is high and the count is all ones.

Some behaviour only the bench scenarios can show. One is that a synchronous clear leaves the count untouched between edges. Another is that an asynchronous clear acts in the middle of a cycle. Another is the carry falling in the same cycle as T. The last is the four-stage chain matching a 16-bit reference, through the wrap at 0xFFFF, through carries between stages and through a full-width load in the middle of a count.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/casc_counter_ctrl.sv
module casc_counter_ctrl
  import casc_counter_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  // Fixed priority: clear, load, count, hold
  always_comb begin
    if (!clr_n)             op = OP_CLEAR;
    else if (!ld_n)         op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/casc_counter_reg.sv
module casc_counter_reg
  import casc_counter_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO;
      OP_LOAD:  nxt = d;
      OP_COUNT: nxt = q + ONE;
      default:  nxt = q;
    endcase
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= ZERO;
        else        q <= nxt;
      end

      // R6
      async_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> q == ZERO);
    end else begin : g_sync
      always_ff @(posedge clk) q <= nxt;

      // R5
      sync_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> q == ZERO);
    end
  endgenerate

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    op == OP_LOAD |=> q == $past(d));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    op == OP_COUNT |=> q == $past(q) + ONE);

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    op == OP_HOLD |=> $stable(q));
endmodule

// File: rtl/casc_counter_carry.sv
module casc_counter_carry #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] cnt,
  input  logic             en_t,
  output logic             rco
);
  localparam logic [WIDTH-1:0] TERMINAL = '1;

  assign rco = en_t && (cnt == TERMINAL);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R7
  carry_needs_t_chk: assert property (@(posedge clk) disable iff (!armed)
    !en_t |-> !rco);

  // R7
  carry_needs_full_chk: assert property (@(posedge clk) disable iff (!armed)
    rco |-> $countones(cnt) == WIDTH);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  cnt_op_e op;

  casc_counter_ctrl u_ctrl (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  casc_counter_reg #(
    .WIDTH     (WIDTH),
    .ASYNC_CLR (ASYNC_CLR)
  ) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .d     (d),
    .q     (q)
  );

  casc_counter_carry #(
    .WIDTH (WIDTH)
  ) u_carry (
    .clk  (clk),
    .cnt  (q),
    .en_t (en_t),
    .rco  (rco)
  );
endmodule

// File: tb/casc_counter_tb.sv
module casc_counter_tb;
  localparam int W  = 4;
  localparam int N  = 4;
  localparam int CW = W * N;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // single synchronous-clear stage
  logic         s_clr_n = 1'b0, s_ld_n = 1'b1, s_p = 1'b0, s_t = 1'b0;
  logic [W-1:0] s_d = '0;
  logic [W-1:0] s_q;
  logic         s_rco;
  logic [W-1:0] sm;

  casc_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_dut (
    .clk(clk), .clr_n(s_clr_n), .ld_n(s_ld_n), .en_p(s_p), .en_t(s_t),
    .d(s_d), .q(s_q), .rco(s_rco)
  );

  // chain of asynchronous-clear stages
  logic          c_clr_n = 1'b0, c_ld_n = 1'b1, c_en = 1'b0;
  logic [CW-1:0] c_d = '0;
  logic [CW-1:0] c_q;
  logic [N:0]    link;
  logic [CW-1:0] cm;

  assign link[0] = c_en;

  for (genvar k = 0; k < N; k++) begin : g_chain
    casc_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) u_stage (
      .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n),
      .en_p(link[k]), .en_t(link[k]),
      .d(c_d[k*W +: W]), .q(c_q[k*W +: W]), .rco(link[k+1])
    );
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic s_step(input logic clr, input logic ld, input logic p,
                        input logic t, input logic [W-1:0] dv);
    string tag;
    s_clr_n = clr; s_ld_n = ld; s_p = p; s_t = t; s_d = dv;
    @(posedge clk);
    if (!clr)          begin sm = '0;       tag = (!ld) ? "R4" : "R5"; end
    else if (!ld)      begin sm = dv;       tag = "R3"; end
    else if (p && t)   begin sm = sm + 1'b1; tag = "R1"; end
    else               tag = "R2";
    @(negedge clk);
    chk(tag, 32'(s_q), 32'(sm));
    chk("R7", 32'(s_rco), 32'(t && (sm == '1)));
  endtask

  task automatic c_step(input logic clr, input logic ld, input logic en,
                        input logic [CW-1:0] dv);
    c_clr_n = clr; c_ld_n = ld; c_en = en; c_d = dv;
    @(posedge clk);
    if (!clr)        cm = '0;
    else if (!ld)    cm = dv;
    else if (en)     cm = cm + 1'b1;
    @(negedge clk);
    chk("R8", 32'(c_q), 32'(cm));
    chk("R8", 32'(link[N]), 32'(en && (cm == '1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    sm = '0;
    cm = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state through clear (R5 synchronous, R6 asynchronous)
    chk("R5", 32'(s_q), 32'd0);
    chk("R6", 32'(c_q), 32'd0);
    c_clr_n = 1'b1;

    // reference run: clear, load 12, count to 2, inhibit
    s_step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0);
    s_step(1'b1, 1'b0, 1'b0, 1'b0, 4'd12);
    for (int i = 0; i < 6; i++) s_step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    chk("R1", 32'(s_q), 32'd2);
    s_step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    s_step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0);
    chk("R2", 32'(s_q), 32'd2);

    // clear beats load (R4)
    s_step(1'b1, 1'b0, 1'b0, 1'b0, 4'd9);
    s_step(1'b0, 1'b0, 1'b1, 1'b1, 4'd5);

    // synchronous clear waits for the edge (R5)
    s_step(1'b1, 1'b0, 1'b0, 1'b0, 4'd9);
    s_clr_n = 1'b0; s_ld_n = 1'b1;
    #3 chk("R5", 32'(s_q), 32'd9);
    s_step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);

    // sweep: every start value against every control combination
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 8; c++) begin
        s_step(1'b1, 1'b0, c[0], c[1], 4'(v));
        s_step(1'b1, c[2], c[1], c[0], 4'(~v));
      end
    end

    // carry: P has no effect, T falls in the same cycle (R7)
    s_step(1'b1, 1'b0, 1'b0, 1'b1, 4'd15);
    s_step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    chk("R7", 32'(s_rco), 32'd1);
    s_t = 1'b0;
    #3 chk("R7", 32'(s_rco), 32'd0);
    s_step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    chk("R1", 32'(s_q), 32'd0);

    // chain: wrap at all ones
    c_step(1'b1, 1'b0, 1'b0, 16'hFFF0);
    for (int i = 0; i < 20; i++) c_step(1'b1, 1'b1, 1'b1, 16'h0);
    chk("R8", 32'(c_q), 32'h0004);
    // stage boundary crossings
    c_step(1'b1, 1'b0, 1'b0, 16'h0FFE);
    for (int i = 0; i < 5; i++) c_step(1'b1, 1'b1, 1'b1, 16'h0);
    // mid-count full-width load, then gated counting
    for (int i = 0; i < 9; i++) c_step(1'b1, 1'b1, 1'b1, 16'h0);
    c_step(1'b1, 1'b0, 1'b1, 16'h12F7);
    for (int i = 0; i < 300; i++) c_step(1'b1, 1'b1, (i % 7) != 3, 16'h0);
    c_step(1'b1, 1'b1, 1'b0, 16'h0);

    // asynchronous clear acts between edges (R6)
    c_step(1'b1, 1'b0, 1'b0, 16'hBEEF);
    c_clr_n = 1'b0;
    #3 chk("R6", 32'(c_q), 32'd0);
    c_step(1'b0, 1'b1, 1'b1, 16'h0);
    c_step(1'b1, 1'b1, 1'b1, 16'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule